// File: doc/BRIEF.md
# Serial Two-Wire Register Port

This block is the target-side front end of an I2C bus for a register space of nine byte locations, numbered 00h to 08h. It runs on a system clock that is at least eight times faster than SCL. It brings SCL and SDA into that clock domain and finds START and STOP conditions and clock edges on the synchronized samples. It drives SDA only through an active-high pull-low enable, so the pad outside the block stays open-drain.

A controller first sends a 7-bit identification byte. That byte is the prefix 1010 followed by the three levels on `dev_sel`. Next comes an address byte, which loads an internal pointer. In a write, the data bytes that follow are handed to an external register bank through a one-cycle write strobe. To read, the controller issues a repeated START and sends the identification byte again with the read bit set. The block then fetches bytes through a one-cycle read strobe and shifts them out. In both directions the pointer steps after every byte and wraps from 08h back to 00h. The register bank reports through `bank_busy` when it cannot accept a write. While that flag is high, data bytes are refused.

Top module: `i2c_regport`

## Requirements
- R1: After reset, `sda_oe` is 0, neither `reg_wr` nor `reg_rd` is active, and `reg_addr` is 0.
- R2: The identification byte is bits 7..4 = 1010, bits 3..1 = `dev_sel[2:0]` and bit 0 = direction (1 read, 0 write), sent MSB first. A match is acknowledged by holding SDA low during the ninth clock. If any bit of bits 7..1 differs, SDA is never pulled low and nothing is strobed until the next START.
- R3: An address byte with a value from 00h to 08h is acknowledged and loads the pointer. An address byte above 08h is not acknowledged, and the block goes idle until the next START.
- R4: When `bank_busy` is low, each write data byte is acknowledged. It produces exactly one `reg_wr` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte, and the pointer then advances by one.
- R5: The pointer advances from 08h to 00h, for both read and write bytes.
- R6: After a repeated START and an identification byte with bit 0 = 1, each data byte is fetched with one `reg_rd` pulse at the current pointer, the pointer advances, and the byte is shifted out MSB first.
- R7: Read bytes continue for as long as the controller acknowledges. After a byte the controller does not acknowledge, SDA is released and the block stays idle until the next START.
- R8: A write data byte that completes while `bank_busy` is high is not acknowledged and issues no `reg_wr`. The register contents and the pointer are left unchanged, and the block goes idle.
- R9: A START at any point, including partway through a byte, abandons the transfer in progress and begins a new identification byte.
- R10: A STOP at any point, including partway through a byte, returns the block to idle. Bytes clocked in afterwards without a START get no acknowledge and no strobe.
- R11: SDA is sampled on SCL rising edges, and `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level as seen at the pad |
| sda_i | input | 1 | Bus data level as seen at the pad |
| dev_sel | input | 3 | Low three bits of the identification byte |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 4 | Pointer presented to the register bank |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rd | output | 1 | One-cycle read strobe; `reg_rdata` is captured in the same cycle |
| reg_rdata | input | 8 | Bank contents at `reg_addr`, combinational |
| bank_busy | input | 1 | Bank cannot take a write; write data is refused |

## Verification
The bench targets the points where the pointer and the framing tend to break. Bursts that cross 08h show whether a design counts up to 0Fh instead of returning to 00h. Mis-prefixed identification bytes and wrong select bits test address matching. A START or STOP inserted partway through a byte exposes a bit counter that does not reset; that design would misalign every later byte and acknowledge at the wrong clock. A write attempted while the bank is busy, followed by a read-back, catches a design that still strobes the bank or advances the pointer on a refused byte. Bytes clocked after a STOP with no START catch a design that leaves standby without being addressed.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

    localparam int LAST_ADDR = 8;
    localparam int PTR_W     = $clog2(LAST_ADDR + 1);
    localparam int PIN_W     = 3;
    localparam int BYTE_W    = 8;
    localparam logic [3:0] ID_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        P_IDLE,
        P_ID,
        P_ADDR,
        P_WR,
        P_RD
    } phase_t;

    // Pointer step with wrap at the last location.
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(LAST_ADDR)) ? '0 : PTR_W'(p + 1'b1);
    endfunction

    // Identification byte check; bit 0 is the direction and is not compared.
    function automatic logic id_hits(input logic [BYTE_W-1:0] b,
                                     input logic [PIN_W-1:0]  pins);
        return (b[BYTE_W-1 -: 4] == ID_PREFIX) && (b[PIN_W:1] == pins);
    endfunction

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    // STAGES flops for metastability, plus one more that holds the previous sample.
    logic [STAGES:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {(STAGES + 1){RST_VAL}};
        end else begin
            stg <= {stg[STAGES-1:0], d};
        end
    end

    assign q      = stg[STAGES-1];
    assign q_prev = stg[STAGES];
endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr
    import i2c_rp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr_next(ptr);
        end
    end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_rp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [PIN_W-1:0]  dev_sel,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic              bank_busy
);
    localparam int              CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_W);

    logic [1:0] lines_s, lines_p;
    logic scl_s, sda_s, scl_p, sda_p;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    i2c_rp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      ({scl_i, sda_i}),
        .q      (lines_s),
        .q_prev (lines_p)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];
    assign scl_p = lines_p[1];
    assign sda_p = lines_p[0];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

    phase_t             phase, nxt, follow;
    logic [CNT_W-1:0]   cnt;
    logic               in_ack, mack, grant;
    logic [BYTE_W-1:0]  shreg;
    logic               byte_done, ack_end, load_rd, wr_go, ptr_load;

    // Acknowledge decision for a completed inbound byte.
    always_comb begin
        grant  = 1'b0;
        follow = P_IDLE;
        unique case (phase)
            P_ID: begin
                grant  = id_hits(shreg, dev_sel);
                follow = shreg[0] ? P_RD : P_ADDR;
            end
            P_ADDR: begin
                grant  = (shreg <= BYTE_W'(LAST_ADDR));
                follow = P_WR;
            end
            P_WR: begin
                grant  = ~bank_busy;
                follow = P_WR;
            end
            default: ;
        endcase
    end

    assign byte_done = scl_fall && !in_ack && (cnt == FULL) &&
                       (phase inside {P_ID, P_ADDR, P_WR});
    assign ack_end   = scl_fall && in_ack;
    assign load_rd   = ack_end && ((phase == P_RD) ? mack : (nxt == P_RD));
    assign wr_go     = byte_done && (phase == P_WR) && grant;
    assign ptr_load  = byte_done && (phase == P_ADDR) && grant;

    assign reg_wr    = wr_go;
    assign reg_wdata = shreg;
    assign reg_rd    = load_rd;

    i2c_rp_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (shreg[PTR_W-1:0]),
        .step     (wr_go | load_rd),
        .ptr      (reg_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= P_IDLE;
            nxt    <= P_IDLE;
            cnt    <= '0;
            in_ack <= 1'b0;
            mack   <= 1'b0;
            shreg  <= '0;
            sda_oe <= 1'b0;
        end else if (bus_start) begin
            phase  <= P_ID;
            cnt    <= '0;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
        end else if (bus_stop) begin
            phase  <= P_IDLE;
            cnt    <= '0;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
        end else if (load_rd) begin
            phase  <= P_RD;
            shreg  <= reg_rdata;
            sda_oe <= ~reg_rdata[BYTE_W-1];
            cnt    <= '0;
            in_ack <= 1'b0;
        end else if (ack_end) begin
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
            cnt    <= '0;
            phase  <= (phase == P_RD) ? P_IDLE : nxt;
        end else if (byte_done) begin
            if (grant) begin
                sda_oe <= 1'b1;
                in_ack <= 1'b1;
                nxt    <= follow;
            end else begin
                sda_oe <= 1'b0;
                phase  <= P_IDLE;
            end
        end else if (phase == P_RD) begin
            if (scl_rise) begin
                if (in_ack) begin
                    mack <= ~sda_s;
                end else if (cnt != FULL) begin
                    cnt <= CNT_W'(cnt + 1'b1);
                end
            end else if (scl_fall && !in_ack) begin
                if (cnt == FULL) begin
                    sda_oe <= 1'b0;
                    in_ack <= 1'b1;
                    mack   <= 1'b0;
                end else begin
                    shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                    sda_oe <= ~shreg[BYTE_W-2];
                end
            end
        end else if ((phase != P_IDLE) && scl_rise && !in_ack && (cnt != FULL)) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= CNT_W'(cnt + 1'b1);
        end
    end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
    import i2c_rp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             scl_lvl,
    input logic             sda_oe,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             bank_busy,
    input logic [PTR_W-1:0] reg_addr,
    input logic             phase_idle
);
    a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

    a_r8_no_write_when_busy: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> !bank_busy);

    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        reg_addr <= PTR_W'(LAST_ADDR));

    a_r5_ptr_wraps: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_wr || reg_rd) && ($past(reg_addr) == PTR_W'(LAST_ADDR)))
        |-> (reg_addr == '0));

    a_r4_ptr_steps: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_wr || reg_rd) && ($past(reg_addr) != PTR_W'(LAST_ADDR)))
        |-> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

    a_r7_idle_released: assert property (@(posedge clk) disable iff (rst)
        phase_idle |-> !sda_oe);
endmodule

bind i2c_regport i2c_regport_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_lvl    (scl_s),
    .sda_oe     (sda_oe),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .bank_busy  (bank_busy),
    .reg_addr   (reg_addr),
    .phase_idle (phase == i2c_rp_pkg::P_IDLE)
);

// File: tb/sim_i2c_regport.sv
`timescale 1ns/1ps
module sim_i2c_regport;
    import i2c_rp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [2:0] pins = 3'b101;
    logic busy = 1'b0;
    logic sda_oe, reg_wr, reg_rd, sda_line;
    logic [PTR_W-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] bank [LAST_ADDR+1];
    logic [7:0] gold [LAST_ADDR+1];
    int total = 0, bad = 0, wr_seen = 0, rd_seen = 0, r11_viol = 0;
    logic oe_q = 1'b0;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = (reg_addr <= PTR_W'(LAST_ADDR)) ? bank[reg_addr] : 8'h00;

    i2c_regport u0 (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .dev_sel(pins),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .bank_busy(busy)
    );

    // Register bank model and strobe counters.
    always @(posedge clk) begin
        if (reg_wr) begin
            bank[reg_addr] <= reg_wdata;
            wr_seen <= wr_seen + 1;
        end
        if (reg_rd) rd_seen <= rd_seen + 1;
        oe_q <= sda_oe;
        if (!rst && (sda_oe !== oe_q) && m_scl) r11_viol <= r11_viol + 1;
    end

    function automatic int nxt(input int p);
        return (p == LAST_ADDR) ? 0 : p + 1;
    endfunction

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold(4);
        m_scl = 1'b1; hold(8);
        m_sda = 1'b0; hold(8);
        m_scl = 1'b0; hold(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(4);
        m_scl = 1'b1; hold(8);
        m_sda = 1'b1; hold(8);
    endtask

    task automatic clk_bit(output logic s);
        m_scl = 1'b1; hold(4);
        s = sda_line; hold(4);
        m_scl = 1'b0; hold(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold(4);
            clk_bit(s);
        end
        m_sda = 1'b1; hold(4);
        clk_bit(s);
        ack = ~s;
    endtask

    task automatic send_bits(input int n);
        logic s;
        for (int i = 0; i < n; i++) begin
            m_sda = 1'b1; hold(4);
            clk_bit(s);
        end
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hold(4);
            clk_bit(s);
            b = {b[6:0], s};
        end
        m_sda = ~give_ack; hold(4);
        clk_bit(s);
    endtask

    task automatic do_write(input int a, input int n);
        logic ack;
        logic [7:0] d;
        int p, w0, wrote;
        w0 = wr_seen; wrote = 0;
        bus_start();
        send_byte({4'b1010, pins, 1'b0}, ack);
        check("R2 id ack on write", ack, 1);
        send_byte(8'(a), ack);
        check("R3 address ack", ack, 1);
        p = a;
        for (int j = 0; j < n; j++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            if (busy) begin
                check("R8 data refused while busy", ack, 0);
                break;
            end
            check("R4 data ack", ack, 1);
            gold[p] = d;
            p = nxt(p);
            wrote++;
        end
        bus_stop();
        check("R4 one write strobe per byte", wr_seen - w0, wrote);
    endtask

    task automatic do_read(input int a, input int n, input string tag);
        logic ack;
        logic [7:0] d;
        int p, r0;
        r0 = rd_seen;
        bus_start();
        send_byte({4'b1010, pins, 1'b0}, ack);
        check("R2 id ack before read", ack, 1);
        send_byte(8'(a), ack);
        check("R3 address ack before read", ack, 1);
        bus_start();
        send_byte({4'b1010, pins, 1'b1}, ack);
        check("R6 id ack with read bit", ack, 1);
        p = a;
        for (int j = 0; j < n; j++) begin
            recv_byte(j < n - 1, d);
            check(tag, d, gold[p]);
            p = nxt(p);
        end
        bus_stop();
        check("R7 SDA released after final NACK", sda_oe, 0);
        check("R6 one read strobe per byte", rd_seen - r0, n);
    endtask

    initial begin
        logic ack;
        int w0;
        void'($urandom(32'd24601));
        for (int i = 0; i <= LAST_ADDR; i++) begin
            bank[i] = 8'h30 + 8'(i);
            gold[i] = 8'h30 + 8'(i);
        end
        hold(6);
        rst = 1'b0;
        hold(3);
        check("R1 SDA released after reset", sda_oe, 0);
        check("R1 no write strobe after reset", reg_wr, 0);
        check("R1 no read strobe after reset", reg_rd, 0);
        check("R1 pointer zero after reset", reg_addr, 0);

        // Basic burst write and read-back.
        do_write(0, 3);
        do_read(0, 3, "R6 read data");
        do_read(3, 2, "R6 untouched data");

        // Wrap from 08h to 00h in both directions.
        do_write(7, 4);
        do_read(8, 3, "R5 wrap on read");
        do_read(6, 5, "R5 wrap after write");

        // Foreign identification bytes.
        w0 = wr_seen;
        bus_start();
        send_byte({4'b1010, ~pins, 1'b0}, ack);
        check("R2 wrong select bits refused", ack, 0);
        send_byte({4'b1010, pins, 1'b0}, ack);
        check("R2 no ack before next START", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, pins, 1'b0}, ack);
        check("R2 wrong prefix refused", ack, 0);
        bus_stop();
        check("R2 no strobe on foreign id", wr_seen - w0, 0);

        // Address out of range.
        bus_start();
        send_byte({4'b1010, pins, 1'b0}, ack);
        check("R2 id ack", ack, 1);
        send_byte(8'h09, ack);
        check("R3 address 09h refused", ack, 0);
        send_byte(8'h55, ack);
        check("R3 idle after refused address", ack, 0);
        bus_stop();
        check("R3 no strobe after refused address", wr_seen - w0, 0);

        // Busy bank refuses writes.
        busy = 1'b1;
        do_write(2, 2);
        busy = 1'b0;
        do_read(2, 2, "R8 register kept after refused write");

        // START partway through a byte.
        bus_start();
        send_bits(4);
        do_write(4, 2);
        do_read(4, 2, "R9 write after mid-id START");
        bus_start();
        send_byte({4'b1010, pins, 1'b0}, ack);
        send_byte(8'h05, ack);
        send_bits(3);
        do_write(6, 1);
        do_read(5, 2, "R9 partial data byte discarded");

        // STOP partway through a byte.
        w0 = wr_seen;
        bus_start();
        send_byte({4'b1010, pins, 1'b0}, ack);
        send_bits(3);
        bus_stop();
        send_byte({4'b1010, pins, 1'b0}, ack);
        check("R10 ignored without START", ack, 0);
        send_byte(8'h03, ack);
        check("R10 second byte ignored", ack, 0);
        bus_stop();
        check("R10 no strobe in standby", wr_seen - w0, 0);
        do_read(0, 1, "R10 next transfer normal");

        // Random mix.
        for (int k = 0; k < 30; k++) begin
            int a, n;
            pins = 3'($urandom);
            a = int'($urandom % 9);
            n = 1 + int'($urandom % 5);
            if ($urandom % 2) do_write(a, n);
            else do_read(a, n, "R6 random read");
        end

        check("R11 SDA moved while SCL high", r11_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule